// File: doc/BRIEF.md
# Hybrid Multilevel Inverter Gate Generator

This block drives the power switches of a three-phase, five-level cascaded hybrid inverter. Each phase stacks a two-switch half-bridge leg, fed from a full supply, with a four-switch H-bridge fed from an isolated half supply. The phase output is the leg voltage (plus or minus half supply) added to the bridge voltage (plus, minus or zero half supply), which gives five levels.

A shared timebase counts system clocks through one fundamental cycle of 50 carrier periods. For every phase and every carrier period, the block derives three logic states. The first is the leg polarity, set by the half cycle. The second is the bridge polarity, set by the half cycle together with the sector. The third is a PWM bit whose pulse width follows one sine law inside the middle sector (angles pi/6 to 5pi/6 of each half cycle) and a different sine law outside it. A small combinational map turns these states into the six leg gates and the twelve bridge gates. The three phases share the timebase, and each reads it through its own angle offset.

The modulation index is an unsigned fraction of 2^MA_W. The block samples it at the start of each carrier period, and a default of 205 gives about 0.8. Raising the enable starts a new fundamental cycle at angle zero. Lowering it turns every switch off.

Top module: `hmi_gate_gen`

## Requirements
- R1: While reset is active, and on every clock after a clock edge that saw enable low, all 18 gate outputs are low.
- R2: While the block runs, exactly one of each phase's leg pair (leg_pos_o, leg_neg_o) is on. For phase a, leg_pos_o is on through every carrier period whose start angle lies in the first half of the fundamental cycle (angle below C/2, where C = CARRIER_CLKS*CARRIERS_PER_CYCLE clocks).
- R3: Switch a is never on together with switch b, and switch c is never on together with switch d. While the block runs, exactly one switch of each of these pairs is on.
- R4: The bridge drives plus when a and d are on and minus when b and c are on. Any other running state is zero. The zero state uses a with c while the leg is positive, and b with d while the leg is negative.
- R5: Within one half cycle, the middle sector covers the angles from C/12 to 5C/12 inclusive, measured from the start of that half cycle. In the positive half cycle, bridge pulses are plus inside the middle sector and minus outside it. The negative half cycle mirrors this.
- R6: In every carrier period, the number of clocks with an active bridge (plus or minus) is within 4 clocks of ma/2^MA_W * CARRIER_CLKS * D. Here s is the sine of the start angle, D = 2s-1 inside the middle sector, D = 1-2s outside it, and D is clamped at 0.
- R7: Width, sector and half-cycle state are sampled once at the start of each carrier period. The active bridge clocks form a single run that begins at the first clock of the period.
- R8: Phase b runs 2C/3 clocks ahead of phase a in angle, and phase c runs C/3 clocks ahead. Both follow the laws of R2, R5 and R6 at their own angles.
- R9: The first output clock after an enable edge reflects angle 0 for phase a. That first carrier period has a minus bridge pulse of exactly floor(ma*CARRIER_CLKS/2^MA_W) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low turns every switch off and rewinds the cycle |
| ma | input | MA_W | Modulation index as a fraction of 2^MA_W |
| leg_pos_o | output | 3 | Per phase: switch tying the leg to the positive rail |
| leg_neg_o | output | 3 | Per phase: switch tying the leg to the negative rail |
| br_a_o | output | 3 | Per phase: bridge upper switch, left side |
| br_b_o | output | 3 | Per phase: bridge lower switch, left side |
| br_c_o | output | 3 | Per phase: bridge upper switch, right side |
| br_d_o | output | 3 | Per phase: bridge lower switch, right side |

## Verification
The checker enforces four properties on every clock. It keeps the two switches of each leg and each bridge half apart. It requires that exactly one switch of each such pair conducts while the block runs. It requires the zero bridge state to follow the leg polarity. It holds every gate off after enable drops. The bench alone can show the properties that depend on angle and time: the sine-law pulse widths, the polarity chosen per sector, the edge-aligned pulse placement, the 120-degree spacing of the phases, and the restart at angle zero. It reconstructs each carrier period from the gate pattern and compares it against a real-valued model of the laws.

// File: rtl/hmi_pkg.sv
package hmi_pkg;

    localparam int SIN_PTS  = 64;
    localparam int SIN_FRAC = 14;
    localparam int SIN_ONE  = 1 << SIN_FRAC;
    localparam int SIN_W    = SIN_FRAC + 1;
    localparam int IDX_W    = $clog2(SIN_PTS);

    // per-phase modulation state, valid for one carrier period
    typedef struct packed {
        logic leg_up;   // leg tied to positive rail
        logic br_pol;   // bridge polarity when pulsing: 1 = plus
        logic pwm;      // bridge pulse active this clock
    } mod_state_t;

    typedef struct packed {
        logic leg_pos;
        logic leg_neg;
        logic sw_a;
        logic sw_b;
        logic sw_c;
        logic sw_d;
    } gate_set_t;

    // Quarter-wave sine sample g of SIN_PTS, scaled to SIN_ONE.
    // Rational approximation over the half period, evaluated at elaboration.
    function automatic int sine_q(input int g);
        int span;
        int prod;
        span = 2 * SIN_PTS;
        prod = g * (span - g);
        return (16 * prod * SIN_ONE) / (5 * span * span - 4 * prod);
    endfunction

endpackage

// File: rtl/hmi_timebase.sv
module hmi_timebase #(
    parameter int CARRIER_CLKS       = 48,
    parameter int CARRIERS_PER_CYCLE = 50,
    parameter int PH_W               = 12,
    parameter int CC_W               = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    output logic [PH_W-1:0] ph_o,
    output logic [CC_W-1:0] cc_o
);
    localparam int CYCLE = CARRIER_CLKS * CARRIERS_PER_CYCLE;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_o <= '0;
            cc_o <= '0;
        end else begin
            ph_o <= (ph_o == PH_W'(CYCLE - 1)) ? '0 : ph_o + 1'b1;
            cc_o <= (cc_o == CC_W'(CARRIER_CLKS - 1)) ? '0 : cc_o + 1'b1;
        end
    end

endmodule

// File: rtl/hmi_phase_mod.sv
module hmi_phase_mod
    import hmi_pkg::*;
#(
    parameter int CARRIER_CLKS = 48,
    parameter int CYCLE        = 2400,
    parameter int PH_W         = 12,
    parameter int CC_W         = 6,
    parameter int MA_W         = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] ang_i,
    input  logic [CC_W-1:0] cc_i,
    input  logic [MA_W-1:0] ma_i,
    output mod_state_t      st_o
);
    localparam int HALF    = CYCLE / 2;
    localparam int QUARTER = CYCLE / 4;
    localparam int SIXTH   = CYCLE / 12;
    localparam int IDX_SH  = 16;
    localparam int IDX_MUL = (SIN_PTS << IDX_SH) / QUARTER;
    localparam int PROD_W  = MA_W + SIN_W + CC_W + 1;

    logic [SIN_W-1:0] sin_tab [SIN_PTS];

    for (genvar g = 0; g < SIN_PTS; g++) begin : g_tab
        assign sin_tab[g] = SIN_W'(sine_q(g));
    end

    int               th, qa, idx;
    logic             neg, mid;
    logic [IDX_W-1:0] idx_s;
    logic [SIN_W:0]   twice;
    logic [SIN_W-1:0] duty;
    logic [PROD_W-1:0] prod;
    logic [CC_W-1:0]  wid_calc;

    always_comb begin
        neg   = int'(ang_i) >= HALF;
        th    = neg ? int'(ang_i) - HALF : int'(ang_i);
        qa    = (th < QUARTER) ? th : HALF - th;
        idx   = (qa * IDX_MUL) >>> IDX_SH;
        if (idx > SIN_PTS - 1) idx = SIN_PTS - 1;
        idx_s = IDX_W'(idx);
        twice = {sin_tab[idx_s], 1'b0};
        mid   = (th >= SIXTH) && (th <= HALF - SIXTH);
        if (mid)
            duty = (twice > (SIN_W+1)'(SIN_ONE)) ? SIN_W'(twice - (SIN_W+1)'(SIN_ONE)) : '0;
        else
            duty = (twice < (SIN_W+1)'(SIN_ONE)) ? SIN_W'((SIN_W+1)'(SIN_ONE) - twice) : '0;
        prod     = PROD_W'(ma_i) * PROD_W'(duty) * PROD_W'(CARRIER_CLKS);
        wid_calc = CC_W'(prod >> (MA_W + SIN_FRAC));
    end

    logic            start;
    logic [CC_W-1:0] wid_q, wid_now;
    logic            up_q, pol_q, up_now, pol_now;

    assign start   = (cc_i == '0);
    assign wid_now = start ? wid_calc : wid_q;
    assign up_now  = start ? !neg : up_q;
    assign pol_now = start ? (!neg == mid) : pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wid_q <= '0;
            up_q  <= 1'b0;
            pol_q <= 1'b0;
        end else if (start) begin
            wid_q <= wid_calc;
            up_q  <= !neg;
            pol_q <= (!neg == mid);
        end
    end

    assign st_o.leg_up = up_now;
    assign st_o.br_pol = pol_now;
    assign st_o.pwm    = (cc_i < wid_now);

endmodule

// File: rtl/hmi_gate_map.sv
module hmi_gate_map
    import hmi_pkg::*;
(
    input  mod_state_t st_i,
    output gate_set_t  gate_o
);
    logic plus_on, idle;

    always_comb begin
        plus_on        = st_i.pwm & st_i.br_pol;
        idle           = !st_i.pwm;
        gate_o.leg_pos = st_i.leg_up;
        gate_o.leg_neg = !st_i.leg_up;
        // zero state parks on the side matching the leg polarity
        gate_o.sw_a    = plus_on | (idle & st_i.leg_up);
        gate_o.sw_d    = plus_on | (idle & !st_i.leg_up);
        gate_o.sw_b    = !gate_o.sw_a;
        gate_o.sw_c    = !gate_o.sw_d;
    end

endmodule

// File: rtl/hmi_gate_gen.sv
module hmi_gate_gen
    import hmi_pkg::*;
#(
    parameter int CARRIER_CLKS       = 48,
    parameter int CARRIERS_PER_CYCLE = 50,
    parameter int MA_W               = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [MA_W-1:0] ma,
    output logic [2:0]      leg_pos_o,
    output logic [2:0]      leg_neg_o,
    output logic [2:0]      br_a_o,
    output logic [2:0]      br_b_o,
    output logic [2:0]      br_c_o,
    output logic [2:0]      br_d_o
);
    localparam int NPH   = 3;
    localparam int CYCLE = CARRIER_CLKS * CARRIERS_PER_CYCLE;
    localparam int PH_W  = $clog2(CYCLE);
    localparam int CC_W  = $clog2(CARRIER_CLKS);

    logic [PH_W-1:0] ph;
    logic [CC_W-1:0] cc;
    gate_set_t       gs [NPH];

    hmi_timebase #(
        .CARRIER_CLKS      (CARRIER_CLKS),
        .CARRIERS_PER_CYCLE(CARRIERS_PER_CYCLE),
        .PH_W              (PH_W),
        .CC_W              (CC_W)
    ) u_tb (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .ph_o(ph),
        .cc_o(cc)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        localparam int OFF = (p * 2 * CYCLE / 3) % CYCLE;
        logic [PH_W:0]   sum;
        logic [PH_W-1:0] ang;
        mod_state_t      st;

        assign sum = {1'b0, ph} + (PH_W+1)'(OFF);
        assign ang = (sum >= (PH_W+1)'(CYCLE)) ? PH_W'(sum - (PH_W+1)'(CYCLE)) : PH_W'(sum);

        hmi_phase_mod #(
            .CARRIER_CLKS(CARRIER_CLKS),
            .CYCLE       (CYCLE),
            .PH_W        (PH_W),
            .CC_W        (CC_W),
            .MA_W        (MA_W)
        ) u_mod (
            .clk  (clk),
            .rst  (rst),
            .ang_i(ang),
            .cc_i (cc),
            .ma_i (ma),
            .st_o (st)
        );

        hmi_gate_map u_map (
            .st_i  (st),
            .gate_o(gs[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            leg_pos_o <= '0;
            leg_neg_o <= '0;
            br_a_o    <= '0;
            br_b_o    <= '0;
            br_c_o    <= '0;
            br_d_o    <= '0;
        end else begin
            for (int p = 0; p < NPH; p++) begin
                leg_pos_o[p] <= gs[p].leg_pos;
                leg_neg_o[p] <= gs[p].leg_neg;
                br_a_o[p]    <= gs[p].sw_a;
                br_b_o[p]    <= gs[p].sw_b;
                br_c_o[p]    <= gs[p].sw_c;
                br_d_o[p]    <= gs[p].sw_d;
            end
        end
    end

endmodule

// File: rtl/hmi_gate_gen_chk.sv
module hmi_gate_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [2:0] leg_pos_o,
    input logic [2:0] leg_neg_o,
    input logic [2:0] br_a_o,
    input logic [2:0] br_b_o,
    input logic [2:0] br_c_o,
    input logic [2:0] br_d_o
);
    assert_off_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> ({leg_pos_o, leg_neg_o, br_a_o, br_b_o, br_c_o, br_d_o} == '0));

    assert_leg_one_on_R2: assert property (@(posedge clk) disable iff (rst)
        $past(en && !rst) |-> ((leg_pos_o ^ leg_neg_o) == 3'b111 && (leg_pos_o & leg_neg_o) == 3'b000));

    assert_bridge_pairs_R3: assert property (@(posedge clk) disable iff (rst)
        ((br_a_o & br_b_o) == 3'b000) && ((br_c_o & br_d_o) == 3'b000));

    assert_bridge_one_on_R3: assert property (@(posedge clk) disable iff (rst)
        $past(en && !rst) |-> ((br_a_o ^ br_b_o) == 3'b111 && (br_c_o ^ br_d_o) == 3'b111));

    assert_zero_follows_leg_R4: assert property (@(posedge clk) disable iff (rst)
        ((br_a_o & br_c_o & ~leg_pos_o) == 3'b000) && ((br_b_o & br_d_o & ~leg_neg_o) == 3'b000));

endmodule

bind hmi_gate_gen hmi_gate_gen_chk u_chk (.*);

// File: tb/hmi_gate_gen_bench.sv
module hmi_gate_gen_bench;

    localparam int T    = 48;
    localparam int NC   = 50;
    localparam int C    = T * NC;
    localparam int H    = C / 2;
    localparam int MA_W = 8;
    localparam real PI  = 3.14159265358979;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en  = 1'b0;
    logic [MA_W-1:0] ma  = '0;
    logic [2:0]      leg_pos, leg_neg, ba, bb, bc, bd;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    hmi_gate_gen #(
        .CARRIER_CLKS      (T),
        .CARRIERS_PER_CYCLE(NC),
        .MA_W              (MA_W)
    ) u_hmi_gate_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ma       (ma),
        .leg_pos_o(leg_pos),
        .leg_neg_o(leg_neg),
        .br_a_o   (ba),
        .br_b_o   (bb),
        .br_c_o   (bc),
        .br_d_o   (bd)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int offset_of(input int p);
        return (p * 2 * C / 3) % C;
    endfunction

    function automatic bit in_mid(input int ang);
        int th;
        th = (ang >= H) ? ang - H : ang;
        return (th >= H / 6) && (th <= H - H / 6);
    endfunction

    function automatic real exp_width(input int ang, input int ma_v);
        int  th;
        real s, d;
        th = (ang >= H) ? ang - H : ang;
        s  = $sin(PI * real'(th) / real'(H));
        d  = in_mid(ang) ? 2.0 * s - 1.0 : 1.0 - 2.0 * s;
        if (d < 0.0) d = 0.0;
        return real'(ma_v) / 256.0 * d * real'(T);
    endfunction

    task automatic check_all_off(input string what);
        check({leg_pos, leg_neg, ba, bb, bc, bd} == '0, "R1", what,
              int'({leg_pos, leg_neg, ba, bb, bc, bd}), 0);
    endtask

    task automatic run_cycle(input int ma_v);
        int  cnt [3];
        bit  idle_seen [3];
        bit  leg_bad [3], pair_bad [3], zero_bad [3], pol_bad [3], run_bad [3];
        @(negedge clk);
        ma = MA_W'(ma_v);
        en = 1'b1;
        for (int n = 0; n < C; n++) begin
            int k, j;
            @(negedge clk);
            k = n / T;
            j = n % T;
            for (int p = 0; p < 3; p++) begin
                int  ang;
                bit  up, pol, plus, minus;
                ang = (k * T + offset_of(p)) % C;
                up  = ang < H;
                pol = (up == in_mid(ang));
                if (j == 0) begin
                    cnt[p] = 0; idle_seen[p] = 0; leg_bad[p] = 0;
                    pair_bad[p] = 0; zero_bad[p] = 0; pol_bad[p] = 0; run_bad[p] = 0;
                end
                if (n == 0 && p == 0) begin
                    check(leg_pos[0] && bb[0] && bc[0] == ((ma_v * T / 256) > 0) || (ma_v * T / 256 == 0),
                          "R9", "angle-zero start: leg positive, minus pulse", int'({leg_pos[0], bb[0], bc[0]}), 3'b111);
                end
                if (leg_pos[p] != up) leg_bad[p] = 1;
                if (!(leg_pos[p] ^ leg_neg[p]) || !(ba[p] ^ bb[p]) || !(bc[p] ^ bd[p])) pair_bad[p] = 1;
                plus  = ba[p] & bd[p];
                minus = bb[p] & bc[p];
                if (plus || minus) begin
                    cnt[p]++;
                    if (plus != pol) pol_bad[p] = 1;
                    if (idle_seen[p]) run_bad[p] = 1;
                end else begin
                    idle_seen[p] = 1;
                    if (up ? !(ba[p] & bc[p]) : !(bb[p] & bd[p])) zero_bad[p] = 1;
                end
                if (j == T - 1) begin
                    real w;
                    w = exp_width(ang, ma_v);
                    check(!leg_bad[p], (p == 0) ? "R2" : "R8", "leg polarity per half cycle", int'(leg_pos[p]), int'(up));
                    check(!pair_bad[p], "R3", "complementary switch pairs", int'(pair_bad[p]), 0);
                    check(!zero_bad[p], "R4", "zero state follows leg", int'(zero_bad[p]), 0);
                    check(!pol_bad[p], "R5", "bridge polarity per sector", int'(pol_bad[p]), 0);
                    check(!run_bad[p], "R7", "single edge-aligned pulse", int'(run_bad[p]), 0);
                    check((real'(cnt[p]) - w <= 4.0) && (w - real'(cnt[p]) <= 4.0),
                          (p == 0) ? "R6" : "R8", "pulse width", cnt[p], int'(w + 0.5));
                    if (k == 0 && p == 0)
                        check(cnt[0] == ma_v * T / 256, "R9", "first carrier exact width", cnt[0], ma_v * T / 256);
                end
            end
        end
        en = 1'b0;
        @(negedge clk);
        check_all_off("all gates off after enable drops");
        repeat (3) @(negedge clk);
        check_all_off("gates stay off while disabled");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        int unsigned seed_init;
        int ma_list [5];
        seed_init = $urandom(32'd4517);
        ma_list[0] = 205;
        ma_list[1] = 0;
        ma_list[2] = 255;
        ma_list[3] = 64 + int'($urandom % 192);
        ma_list[4] = 64 + int'($urandom % 192);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all_off("reset state");
        en = 1'b1;
        ma = 8'd205;
        repeat (2) @(negedge clk);
        check_all_off("enable ignored during reset");
        en  = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_all_off("idle after reset release");
        for (int r = 0; r < 5; r++) begin
            run_cycle(ma_list[r]);
            repeat (1 + int'($urandom % 5)) @(negedge clk);
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule